// File: doc/BRIEF.md
# Two-phase dual-rail word deserializer

This block receives a serial bit stream carried on a two-wire level-encoded dual-rail pair, a phase wire and a state wire. It needs no bit clock. For every bit the transmitter changes exactly one of the two wires. The receiver samples both wires each clock and keeps a one-bit parity tracker. It detects a new bit whenever the XOR of the two wires differs from that tracker. The value of the bit is the level of the state wire after the change.

Received bits are dealt round-robin to M narrow shift registers. Only the dispatch step runs at the full bit rate, and each lane shifts once every M bits. When the last bit of a word arrives, the lanes are interleaved back into a W-bit word. That word is offered on a valid/ready output. When the word is taken, a two-phase acknowledge level toggles once, which tells the transmitter that it may send the next word. Protocol violations raise a one-cycle error pulse. One violation is both wires changing in one sample. The other is a word finishing while the previous one is still unclaimed.

Top module: `ledr_word_rx`

## Requirements
- R1: While reset is asserted and after its release, word_valid, ack_lvl and proto_err are 0, and the parity tracker and bit counter are cleared. The line is taken as idle at phase=0, state=0.
- R2: A bit is counted only in a sample where exactly one of line_p and line_s differs from the previous sample. A sample in which neither wire changes adds no bit, however long the line stays idle.
- R3: The value of each received bit is the level of line_s in the sample where the bit is detected.
- R4: Bits fill the word starting at bit 0. The first bit received after a completed word becomes word_data[0] and the W-th becomes word_data[W-1]. Bit i is held in lane i mod M until assembly.
- R5: word_valid rises in the cycle after the clock edge that samples the W-th bit. While word_valid=1 and word_ready=0, word_valid and word_data stay unchanged.
- R6: ack_lvl toggles exactly once at each clock edge where word_valid=1 and word_ready=1 (the word is taken). At every other edge it holds its value.
- R7: If line_p and line_s both change in the same sample, proto_err is 1 for exactly the following cycle and no bit is counted.
- R8: If a word completes while the previous word is pending and not being taken in that cycle, proto_err pulses for one cycle. The new word is dropped and the pending word_data is kept.
- R9: If a word completes in the same cycle that the pending word is taken, the new word is loaded, word_valid stays 1, ack_lvl toggles and proto_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, at least one rising edge per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| line_p | input | 1 | Phase wire of the dual-rail pair (already synchronized) |
| line_s | input | 1 | State wire of the dual-rail pair, carries the data level |
| word_ready | input | 1 | Consumer accepts the presented word |
| word_valid | output | 1 | An assembled word is presented |
| word_data | output | W | Assembled word, first received bit in bit 0 |
| ack_lvl | output | 1 | Two-phase word acknowledge toward the transmitter |
| proto_err | output | 1 | One-cycle pulse on a protocol violation |

## Verification
The bench builds the block with W=16 and M=4. Each word therefore passes through four lanes of four slots. The lane rotation wraps four times per word, so an interleaving mistake in any lane or slot shows up as a wrong bit. The random words arrive with random idle gaps between bits. They include all-zero and all-one patterns, where only the phase wire moves. Directed sequences drive a double-wire change, an overrun while a word is held and a completion that coincides with acceptance.

// File: rtl/ledr_rx_pkg.sv
package ledr_rx_pkg;

    // Per-sample result of the line decoder
    typedef struct packed {
        logic evt;   // a new bit was detected in this sample
        logic val;   // value of that bit
        logic dbl;   // both wires changed (protocol violation)
    } rx_evt_t;

endpackage

// File: rtl/ledr_evt_det.sv
module ledr_evt_det
    import ledr_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    p_i,
    input  logic    s_i,
    output rx_evt_t ev_o
);

    typedef struct packed {
        logic p;
        logic s;
        logic par;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        ev_o.evt  = (p_i ^ s_i) ^ det_q.par;
        ev_o.val  = s_i;
        ev_o.dbl  = (p_i != det_q.p) && (s_i != det_q.s);
        det_d.p   = p_i;
        det_d.s   = s_i;
        det_d.par = det_q.par ^ ev_o.evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

endmodule

// File: rtl/ledr_lane.sv
module ledr_lane #(
    parameter int L = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         din_i,
    output logic [L-1:0] nxt_o
);

    logic [L-1:0] slots_q;

    generate
        if (L == 1) begin : g_single
            always_comb nxt_o = en_i ? din_i : slots_q;
        end else begin : g_multi
            always_comb nxt_o = en_i ? {din_i, slots_q[L-1:1]} : slots_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) slots_q <= '0;
        else        slots_q <= nxt_o;
    end

endmodule

// File: rtl/ledr_word_rx.sv
module ledr_word_rx
    import ledr_rx_pkg::*;
#(
    parameter int W = 16,
    parameter int M = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         line_p,
    input  logic         line_s,
    input  logic         word_ready,
    output logic         word_valid,
    output logic [W-1:0] word_data,
    output logic         ack_lvl,
    output logic         proto_err
);

    localparam int LW = W / M;
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          vld;
        logic [W-1:0]  word;
        logic          ack;
        logic          err;
    } st_t;

    st_t st_d, st_q;

    rx_evt_t       ev;
    logic [CW-1:0] lane_idx;
    logic [M-1:0]  lane_en;
    logic [LW-1:0] lane_nxt [M];
    logic [W-1:0]  word_nxt;
    logic          accept;
    logic          done;

    ledr_evt_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .p_i   (line_p),
        .s_i   (line_s),
        .ev_o  (ev)
    );

    assign lane_idx = st_q.cnt % CW'(M);

    generate
        for (genvar g = 0; g < M; g++) begin : g_lane
            assign lane_en[g] = ev.evt && (lane_idx == CW'(g));

            ledr_lane #(.L(LW)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (lane_en[g]),
                .din_i (ev.val),
                .nxt_o (lane_nxt[g])
            );

            for (genvar k = 0; k < LW; k++) begin : g_slot
                assign word_nxt[k*M + g] = lane_nxt[g][k];
            end
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        accept   = st_q.vld && word_ready;
        done     = ev.evt && (st_q.cnt == CW'(W - 1));

        if (accept) begin
            st_d.vld = 1'b0;
            st_d.ack = ~st_q.ack;
        end

        if (ev.evt) begin
            st_d.cnt = done ? '0 : st_q.cnt + 1'b1;
        end

        if (done) begin
            if (st_q.vld && !accept) begin
                st_d.err = 1'b1;
            end else begin
                st_d.vld  = 1'b1;
                st_d.word = word_nxt;
            end
        end

        if (ev.dbl) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_valid = st_q.vld;
    assign word_data  = st_q.word;
    assign ack_lvl    = st_q.ack;
    assign proto_err  = st_q.err;

endmodule

// File: rtl/ledr_word_rx_chk.sv
module ledr_word_rx_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         line_p,
    input logic         line_s,
    input logic         word_ready,
    input logic         word_valid,
    input logic [W-1:0] word_data,
    input logic         ack_lvl,
    input logic         proto_err
);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!word_valid && !ack_lvl && !proto_err));

    // R6
    ack_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> (ack_lvl != $past(ack_lvl)));

    // R6
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid && word_ready) |=> $stable(ack_lvl));

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

    // R7
    dbl_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (line_p != $past(line_p)) && (line_s != $past(line_s)))
        |=> proto_err);

endmodule

bind ledr_word_rx ledr_word_rx_chk #(.W(W)) u_chk (.*);

// File: tb/sim_ledr_word_rx.sv
module sim_ledr_word_rx;

    localparam int W = 16;
    localparam int M = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         p = 1'b0;
    logic         s = 1'b0;
    logic         rdy = 1'b0;
    logic         vld;
    logic [W-1:0] data;
    logic         ack;
    logic         err;

    int   errs = 0;
    int   checks = 0;
    logic exp_ack = 1'b0;
    bit   finished = 0;

    always #10 clk = ~clk;

    ledr_word_rx #(.W(W), .M(M)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_p     (p),
        .line_s     (s),
        .word_ready (rdy),
        .word_valid (vld),
        .word_data  (data),
        .ack_lvl    (ack),
        .proto_err  (err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Exactly one wire changes; state wire carries the bit value
    task automatic drive_bit(input bit b);
        @(negedge clk);
        if (b == s) p = ~p;
        else        s = b;
    endtask

    task automatic send_bits(input logic [W-1:0] w, input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps) repeat ($urandom % 3) @(negedge clk);
            drive_bit(w[i]);
        end
    endtask

    task automatic expect_word(input logic [W-1:0] w, input string req);
        @(negedge clk);
        chk(vld == 1'b1, {req, " valid"}, 32'(vld), 32'd1);
        chk(data == w, {req, " word"}, 32'(data), 32'(w));
        chk(err == 1'b0, {req, " no error"}, 32'(err), 32'd0);
    endtask

    task automatic accept_word();
        rdy = 1'b1;
        @(negedge clk);
        exp_ack = ~exp_ack;
        chk(vld == 1'b0, "R6 valid drops on accept", 32'(vld), 32'd0);
        chk(ack == exp_ack, "R6 ack toggles on accept", 32'(ack), 32'(exp_ack));
        rdy = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w;
        logic [W-1:0] wa;
        logic [W-1:0] wb;
        void'($urandom(32'd1234));

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(vld == 1'b0, "R1 valid in reset", 32'(vld), 32'd0);
        chk(ack == 1'b0, "R1 ack in reset", 32'(ack), 32'd0);
        chk(err == 1'b0, "R1 err in reset", 32'(err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vld == 1'b0 && ack == 1'b0, "R1 after release", 32'({vld, ack}), 32'd0);

        // R2 idle line yields nothing
        repeat (10) @(negedge clk);
        chk(vld == 1'b0, "R2 idle no word", 32'(vld), 32'd0);

        // R5 hold while not ready, R3/R4 bit order
        wa = 16'hA5C3;
        send_bits(wa, W, 0);
        expect_word(wa, "R4 R3 directed");
        repeat (3) @(negedge clk);
        chk(vld == 1'b1 && data == wa, "R5 held word", 32'(data), 32'(wa));
        chk(ack == exp_ack, "R6 ack stable while held", 32'(ack), 32'(exp_ack));
        accept_word();

        // Pattern words and random words with gaps, consumer always ready
        rdy = 1'b1;
        for (int n = 0; n < 40; n++) begin
            case (n)
                0: w = '0;
                1: w = '1;
                2: w = 16'h5555;
                3: w = 16'h8001;
                default: w = W'($urandom);
            endcase
            send_bits(w, W, n >= 4);
            expect_word(w, "R2 R4 stream");
            @(negedge clk);
            exp_ack = ~exp_ack;
            chk(vld == 1'b0, "R5 single-cycle valid when ready", 32'(vld), 32'd0);
            chk(ack == exp_ack, "R6 ack per word", 32'(ack), 32'(exp_ack));
        end
        rdy = 1'b0;

        // R7 both wires change together
        @(negedge clk);
        p = ~p;
        s = ~s;
        @(negedge clk);
        chk(err == 1'b1, "R7 error pulse", 32'(err), 32'd1);
        @(negedge clk);
        chk(err == 1'b0, "R7 pulse ends", 32'(err), 32'd0);
        w = 16'h1234;
        send_bits(w, W, 0);
        expect_word(w, "R7 no bit counted");
        accept_word();

        // R8 overrun keeps pending word
        wa = 16'h0F0F;
        wb = 16'hBEEF;
        send_bits(wa, W, 0);
        expect_word(wa, "R8 first word");
        send_bits(wb, W, 0);
        @(negedge clk);
        chk(err == 1'b1, "R8 overrun error", 32'(err), 32'd1);
        chk(data == wa, "R8 pending word kept", 32'(data), 32'(wa));
        @(negedge clk);
        chk(err == 1'b0, "R8 pulse ends", 32'(err), 32'd0);
        accept_word();
        @(negedge clk);
        chk(vld == 1'b0, "R8 dropped word not shown", 32'(vld), 32'd0);

        // R9 completion coincides with acceptance
        wa = 16'hC001;
        wb = 16'h7E3A;
        send_bits(wa, W, 0);
        expect_word(wa, "R9 first word");
        send_bits(wb, W - 1, 0);
        @(negedge clk);
        rdy = 1'b1;
        if (wb[W-1] == s) p = ~p;
        else              s = wb[W-1];
        @(negedge clk);
        rdy = 1'b0;
        exp_ack = ~exp_ack;
        chk(vld == 1'b1, "R9 valid stays", 32'(vld), 32'd1);
        chk(data == wb, "R9 new word loaded", 32'(data), 32'(wb));
        chk(ack == exp_ack, "R9 ack toggled", 32'(ack), 32'(exp_ack));
        chk(err == 1'b0, "R9 no error", 32'(err), 32'd0);
        accept_word();

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule